// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block lets a clocked host read and write one byte at a time in an external asynchronous static RAM. The RAM has 20 address lines, an 8-bit data bus that both sides may drive, and three active-low strobes: chip select, write strobe and output gate. The host presents an address, write data and a write flag under a valid/ready handshake. Read data comes back with a one-cycle valid pulse. The data bus leaves the block as three pad-side signals: drive value, drive enable and sampled value. The pad ring ties these to the bidirectional pins.

The RAM's timing limits are parameters in picoseconds, along with the clock period. Each limit becomes a whole number of cycles by rounding up, with a floor of one cycle. A state machine built from these counts sequences the strobes. It has six states. `ST_IDLE` is standby: all strobes high, no drive, host ready. `ST_RD` holds chip select and output gate low for the read access time. `ST_TURN` is a read-to-write bus gap. `ST_WR_REL` pulls the write strobe low while drivers stay off so the RAM can release the bus. `ST_WR_DRV` drives data with the write strobe still low. `ST_WR_END` raises all strobes and keeps data driven for one hold cycle.

The transitions are as follows. From `ST_IDLE`, a read request goes to `ST_RD`. A write request goes to `ST_TURN` if the previous access was a read, otherwise to `ST_WR_REL`. `ST_RD` returns to `ST_IDLE` when its timer expires. `ST_TURN` moves to `ST_WR_REL` when its timer expires, and `ST_WR_REL` then moves to `ST_WR_DRV` the same way. `ST_WR_DRV` moves to `ST_WR_END` when its timer expires. `ST_WR_END` always goes to `ST_IDLE` after one cycle.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, chip select, write strobe and output gate are high, the data drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: While no access is in progress (`req_ready` high), all three strobes are high and the data drive enable is low.
- R3: A read holds chip select and output gate low, with the write strobe high, for exactly RD_CYC consecutive cycles. RD_CYC is the largest of the rounded address-access, output-gate-access and read-cycle times. `mem_addr` does not change while chip select is low.
- R4: Read data is sampled on the clock edge that ends the read strobes. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle: the first cycle after chip select rises. The data equals the RAM content at the requested address, and every accepted read produces one response.
- R5: During a write the output gate stays high throughout, and `mem_addr` does not change while chip select is low.
- R6: During a write the drive enable stays low for the first HZ_CYC cycles of the write strobe being low. HZ_CYC is the rounded bus-release time. The drive enable is then high for the remaining cycles, and stays high with unchanged data for one cycle after both strobes rise.
- R7: The write strobe stays low for exactly HZ_CYC + DATA_CYC cycles. DATA_CYC is the larger of the rounded data-setup time and the part of the minimum strobe width (largest of the write pulse, address-to-end and cycle-time-minus-one counts) not already covered by HZ_CYC, and is at least one.
- R8: A write that follows a read has at least HZ_CYC + 1 cycles between the read's chip select rising and the write's chip select falling. The gap is exactly HZ_CYC + 1 when the write is presented back to back. Neither side drives the bus during the gap.
- R9: `req_ready` falls in the cycle after a request is accepted and stays low while chip select is low.
- R10: The drive enable is never high while chip select and output gate are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | RAM address lines |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output gate, active low |
| mem_dq_out | output | DATA_W | Value to drive onto the RAM data bus |
| mem_dq_oe | output | 1 | Drive enable for the RAM data bus |
| mem_dq_in | input | DATA_W | Value sampled from the RAM data bus |

## Verification
The read response pulse and the acceptance of the next request fall in the same cycle. That cycle is the first standby cycle after a read, where `rsp_valid` and `req_ready` are both high. The bench provokes this by holding a write request ready while a read completes. It then judges two things: the returned byte matches the arithmetic pattern last written there, and the write's chip select falls exactly HZ_CYC + 1 cycles after the read's rose. The memory model presents garbage until the access time has elapsed, so a sample taken one edge early, or a turnaround that is skipped or doubled, shows up as a wrong value or a wrong gap.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WR_REL,
        ST_WR_DRV,
        ST_WR_END
    } ctl_state_e;

    // Round a time budget up to whole clock cycles, never below one cycle.
    function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned RD_CYC   = 1,
    parameter int unsigned HZ_CYC   = 1,
    parameter int unsigned DATA_CYC = 1,
    parameter int unsigned TA_CYC   = 1,
    parameter int          CNT_W    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             req_ready,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             drv_en
);

    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LD   = CNT_W'(HZ_CYC - 1);
    localparam logic [CNT_W-1:0] DATA_LD = CNT_W'(DATA_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LD   = CNT_W'(TA_CYC - 1);

    ctl_state_e state_q, state_d;
    logic       last_rd_q;

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign capture = (state_q == ST_RD) && tmr_done;

    // Next state and timer load.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d = last_rd_q ? ST_TURN : ST_WR_REL;
                    end else begin
                        state_d = ST_RD;
                    end
                end
            end
            ST_RD:     if (tmr_done) state_d = ST_IDLE;
            ST_TURN:   if (tmr_done) state_d = ST_WR_REL;
            ST_WR_REL: if (tmr_done) state_d = ST_WR_DRV;
            ST_WR_DRV: if (tmr_done) state_d = ST_WR_END;
            ST_WR_END: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (state_d != state_q) begin
            tmr_load = 1'b1;
            unique case (state_d)
                ST_RD:     tmr_val = RD_LD;
                ST_TURN:   tmr_val = TA_LD;
                ST_WR_REL: tmr_val = HZ_LD;
                ST_WR_DRV: tmr_val = DATA_LD;
                default:   tmr_val = '0;
            endcase
        end
    end

    // State register and read-history flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            last_rd_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                last_rd_q <= 1'b1;
            end else if (state_q == ST_WR_REL) begin
                last_rd_q <= 1'b0;
            end
        end
    end

    // Registered outputs, decoded from the next state so they track state_q glitch-free.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n      <= 1'b1;
            we_n      <= 1'b1;
            oe_n      <= 1'b1;
            drv_en    <= 1'b0;
            req_ready <= 1'b1;
        end else begin
            ce_n      <= !(state_d inside {ST_RD, ST_WR_REL, ST_WR_DRV});
            we_n      <= !(state_d inside {ST_WR_REL, ST_WR_DRV});
            oe_n      <= (state_d != ST_RD);
            drv_en    <= (state_d inside {ST_WR_DRV, ST_WR_END});
            req_ready <= (state_d == ST_IDLE);
        end
    end

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (ce_n && we_n && oe_n && !drv_en)); // R2
    AST_GATE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> oe_n); // R5
    AST_DRIVE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $rose(drv_en) |-> (!we_n && $past(!we_n))); // R6
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n) (!ce_n && !oe_n) |-> !drv_en); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) !ce_n |-> !req_ready); // R9
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n) accept |=> !req_ready); // R9

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= mem_dq_in;
            end
        end
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R4

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int          ADDR_W   = 20,
    parameter int          DATA_W   = 8,
    parameter int unsigned T_CLK_PS = 10000,
    parameter int unsigned T_AA_PS  = 10000,
    parameter int unsigned T_OE_PS  = 4500,
    parameter int unsigned T_RC_PS  = 10000,
    parameter int unsigned T_WC_PS  = 10000,
    parameter int unsigned T_WP_PS  = 8000,
    parameter int unsigned T_AW_PS  = 8000,
    parameter int unsigned T_DW_PS  = 6000,
    parameter int unsigned T_HZ_PS  = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned RD_CYC   = umax(umax(ps_to_cyc(T_AA_PS, T_CLK_PS), ps_to_cyc(T_OE_PS, T_CLK_PS)),
                                            ps_to_cyc(T_RC_PS, T_CLK_PS));
    localparam int unsigned HZ_CYC   = ps_to_cyc(T_HZ_PS, T_CLK_PS);
    localparam int unsigned WC_LOW   = (ps_to_cyc(T_WC_PS, T_CLK_PS) > 1) ? ps_to_cyc(T_WC_PS, T_CLK_PS) - 1 : 1;
    localparam int unsigned WE_MIN   = umax(umax(ps_to_cyc(T_WP_PS, T_CLK_PS), ps_to_cyc(T_AW_PS, T_CLK_PS)), WC_LOW);
    localparam int unsigned DATA_CYC = umax(ps_to_cyc(T_DW_PS, T_CLK_PS), (WE_MIN > HZ_CYC) ? WE_MIN - HZ_CYC : 1);
    localparam int unsigned TA_CYC   = HZ_CYC;
    localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, HZ_CYC), DATA_CYC);
    localparam int          CNT_W    = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             accept;
    logic             capture;

    sram_ctrl_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctrl_fsm #(
        .RD_CYC   (RD_CYC),
        .HZ_CYC   (HZ_CYC),
        .DATA_CYC (DATA_CYC),
        .TA_CYC   (TA_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture),
        .req_ready (req_ready),
        .ce_n      (mem_ce_n),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .drv_en    (mem_dq_oe)
    );

    sram_ctrl_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .capture    (capture),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) !mem_ce_n |=> (mem_ce_n || $stable(mem_addr))); // R3
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(rsp_valid) |-> ($rose(mem_ce_n) && $past(!mem_oe_n))); // R4

endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

    localparam int unsigned K_CLK = 10000;
    localparam int unsigned K_AA  = 25000;
    localparam int unsigned K_OE  = 4500;
    localparam int unsigned K_RC  = 10000;
    localparam int unsigned K_WC  = 10000;
    localparam int unsigned K_WP  = 28000;
    localparam int unsigned K_AW  = 8000;
    localparam int unsigned K_DW  = 16000;
    localparam int unsigned K_HZ  = 14000;

    function automatic int cyc(input int unsigned t);
        int c;
        c = int'((t + K_CLK - 1) / K_CLK);
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RD_E   = imax(imax(cyc(K_AA), cyc(K_OE)), cyc(K_RC));
    localparam int HZ_E   = cyc(K_HZ);
    localparam int WCL_E  = (cyc(K_WC) > 1) ? cyc(K_WC) - 1 : 1;
    localparam int WEM_E  = imax(imax(cyc(K_WP), cyc(K_AW)), WCL_E);
    localparam int DATA_E = imax(cyc(K_DW), (WEM_E > HZ_E) ? WEM_E - HZ_E : 1);
    localparam int TA_E   = HZ_E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    always #5 clk = ~clk;

    sram_ctrl #(
        .ADDR_W(20), .DATA_W(8), .T_CLK_PS(K_CLK), .T_AA_PS(K_AA), .T_OE_PS(K_OE),
        .T_RC_PS(K_RC), .T_WC_PS(K_WC), .T_WP_PS(K_WP), .T_AW_PS(K_AW),
        .T_DW_PS(K_DW), .T_HZ_PS(K_HZ)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int compared = 0;
    int mismatched = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural RAM: output is garbage until the access time has elapsed.
    logic [7:0] model [256];
    int         rd_age = 0;
    logic [7:0] wbuf = '0;
    logic       wseen = 1'b0;
    logic       m_pwe = 1'b1;
    wire        rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;

    assign mem_dq_in = rd_on ? ((rd_age >= RD_E - 1) ? model[mem_addr[7:0]] : 8'hEE) : 8'h00;

    always @(posedge clk) begin
        rd_age <= rd_on ? rd_age + 1 : 0;
        m_pwe  <= mem_we_n;
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            wbuf  <= mem_dq_out;
            wseen <= 1'b1;
        end
        if (mem_we_n && !m_pwe && wseen) begin
            model[mem_addr[7:0]] <= wbuf;
            wseen <= 1'b0;
        end
    end

    // Expected read responses.
    logic [7:0] shadow [256];
    logic [7:0] exp_q [1024];
    int         q_head = 0;
    int         q_tail = 0;
    bit         b2b = 0;

    // Port monitor, sampled away from the active edge.
    logic        pce = 1'b1, pwe = 1'b1, prsp = 1'b0;
    int          ce_run = 0, we_run = 0, gap_run = 0;
    bit          last_rd = 0, addr_ok = 1, drv_bad = 0, oe_bad = 0, busy_rdy = 0, gap_drv = 0, stab_bad = 0, seen_drv = 0;
    logic [19:0] addr_at_fall = '0;
    logic [7:0]  dval = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_on) chk(!mem_dq_oe, "R10 drive during read", int'(mem_dq_oe), 0);
            if (!mem_ce_n && pce) begin
                addr_at_fall = mem_addr;
                ce_run = 0; we_run = 0;
                addr_ok = 1; drv_bad = 0; oe_bad = 0; busy_rdy = 0; stab_bad = 0; seen_drv = 0;
                if (!mem_we_n && last_rd) begin
                    chk(gap_run >= TA_E + 1, "R8 turnaround gap min", gap_run, TA_E + 1);
                    if (b2b) chk(gap_run == TA_E + 1, "R8 turnaround gap back-to-back", gap_run, TA_E + 1);
                    chk(!gap_drv, "R8 bus driven in gap", int'(gap_drv), 0);
                end
            end
            if (!mem_ce_n) begin
                ce_run++;
                if (mem_addr != addr_at_fall) addr_ok = 0;
                if (req_ready) busy_rdy = 1;
            end
            if (!mem_we_n) begin
                we_run++;
                if (!mem_oe_n) oe_bad = 1;
                if (mem_dq_oe != (we_run > HZ_E)) drv_bad = 1;
                if (mem_dq_oe) begin
                    if (!seen_drv) dval = mem_dq_out;
                    else if (mem_dq_out != dval) stab_bad = 1;
                    seen_drv = 1;
                end
            end
            if (mem_ce_n && !pce) begin
                gap_run = 1; gap_drv = 0;
                if (!pwe) begin
                    chk(we_run == HZ_E + DATA_E, "R7 write strobe length", we_run, HZ_E + DATA_E);
                    chk(!drv_bad, "R6 drive enable timing", int'(drv_bad), 0);
                    chk(mem_dq_oe && mem_dq_out == dval && !stab_bad, "R6 data hold", int'(mem_dq_out), int'(dval));
                    chk(!oe_bad, "R5 output gate low in write", int'(oe_bad), 0);
                    chk(addr_ok, "R5 address moved in write", int'(mem_addr), int'(addr_at_fall));
                    chk(!busy_rdy, "R9 ready high during write", int'(busy_rdy), 0);
                    last_rd = 0;
                end else begin
                    chk(ce_run == RD_E, "R3 read strobe length", ce_run, RD_E);
                    chk(addr_ok, "R3 address moved in read", int'(mem_addr), int'(addr_at_fall));
                    chk(!busy_rdy, "R9 ready high during read", int'(busy_rdy), 0);
                    last_rd = 1;
                end
            end else if (mem_ce_n) begin
                gap_run++;
                if (last_rd && mem_dq_oe) gap_drv = 1;
            end
            if (rsp_valid) begin
                chk(last_rd && gap_run == 1 && !prsp, "R4 response timing", gap_run, 1);
                if (q_head < q_tail) begin
                    chk(rsp_rdata == exp_q[q_head], "R4 read data", int'(rsp_rdata), int'(exp_q[q_head]));
                    q_head++;
                end else begin
                    chk(0, "R4 unexpected response", 1, 0);
                end
            end
            pce = mem_ce_n; pwe = mem_we_n; prsp = rsp_valid;
        end
    end

    task automatic issue(input bit wr, input int idx, input logic [7:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {12'(idx ^ 8'h5A), 8'(idx)};
        req_wdata = d;
        if (wr) shadow[idx] = d;
        else begin exp_q[q_tail] = shadow[idx]; q_tail++; end
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        chk(!req_ready, "R9 ready after accept", int'(req_ready), 0);
        req_valid = 1'b0;
    endtask

    task automatic idle_check(input int n);
        while (!req_ready) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R2 standby strobes",
                int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}), 4'b1110);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin model[i] = 8'h00; shadow[i] = 8'h00; end
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes in reset", int'({mem_ce_n, mem_we_n, mem_oe_n}), 3'b111);
        chk(!mem_dq_oe, "R1 drive in reset", int'(mem_dq_oe), 0);
        chk(req_ready, "R1 ready in reset", int'(req_ready), 1);
        chk(!rsp_valid, "R1 response in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check(4);
        for (int i = 0; i < 256; i++) issue(1'b1, i, 8'(i * 37 + 11));
        idle_check(5);
        for (int i = 0; i < 256; i++) issue(1'b0, i, 8'h00);
        idle_check(5);
        b2b = 1;
        for (int i = 0; i < 256; i++) begin
            issue(1'b0, i, 8'h00);
            issue(1'b1, i, 8'(i * 101 + 7) ^ 8'hC3);
            issue(1'b0, i, 8'h00);
        end
        idle_check(10);
        chk(q_head == q_tail, "R4 all reads answered", q_head, q_tail);
        finish_run();
    end

endmodule